// File: doc/BRIEF.md
# Double-Buffered Event Timestamp Capture

This block is a single input-capture channel attached to a free-running timer. When a capture event arrives and the channel is armed, the block stores the counter value from that same clock as a timestamp. The timestamp first goes into a hidden one-entry holding buffer. It then moves into the visible capture register, which is the only place software can read it. Together the two stages act as a two-deep FIFO.

The buffer empties into the visible register in two cases: when the register holds nothing, or when the register is being read. A channel flag rises whenever a value lands in the visible register. That flag serves as the request line for interrupt, event or DMA logic. If an event arrives while the buffer is still occupied, the block drops the timestamp and raises an error flag.

In dual-slope operation with a short period, the top bit of the stored value is replaced by the count direction. This lets software tell which ramp the capture came from.

Top module: `evt_capture_chan`

## Requirements
- R1: A capture is accepted only when `evt_strobe`, `evt_in_en` and `cap_en` are all 1 at the same clock edge. Any other event leaves `buf_valid`, `chan_flag` and `cap_value` unchanged.
- R2: An accepted capture stores the `cnt_value` present at that edge. With both stages empty, `buf_valid` is 1 after that edge. One edge later, `cap_value` shows the stamp and `chan_flag` is 1.
- R3: A valid buffer moves into the visible register at the first edge where the visible register is empty or `rd_strobe` is 1. After a read edge with a full buffer, `cap_value` already shows the buffered value.
- R4: `chan_flag` is set by every buffer-to-register transfer. A read clears it unless a transfer happens at the same edge. `clr_chan_flag` = 1 clears it, and a transfer at that same edge wins. While `chan_flag` is 1, the visible register holds data.
- R5: Timestamps are read out through `cap_value` in the order they were captured.
- R6: An accepted capture that arrives while `buf_valid` is 1 is discarded and sets `err_flag`. The values already held in both stages are kept.
- R7: `clr_err_flag` = 1 clears `err_flag`, unless an overflow occurs at the same edge.
- R8: When `dual_slope` and `top_below_half` are both 1, the stored bit CNT_W-1 equals `cnt_down` (0 = rising ramp, 1 = falling ramp). Otherwise it is the counter bit.
- R9: Reset (`rst_n` = 0, asynchronous) clears both stages, `chan_flag` and `err_flag`.
- R10: `buf_valid` is 1 exactly while the hidden buffer holds a timestamp that has not yet moved to the visible register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in_en | input | 1 | Event input enable for this channel |
| cap_en | input | 1 | Channel works in capture mode |
| dual_slope | input | 1 | Timer runs dual-slope |
| top_below_half | input | 1 | Period top is below half of the counter maximum |
| cnt_down | input | 1 | Current count direction, 1 = down |
| cnt_value | input | CNT_W | Current counter value |
| evt_strobe | input | 1 | Capture event, one cycle per event |
| rd_strobe | input | 1 | Visible register is read this cycle |
| clr_chan_flag | input | 1 | Write-one-to-clear for the channel flag |
| clr_err_flag | input | 1 | Write-one-to-clear for the error flag |
| cap_value | output | CNT_W | Visible capture register |
| chan_flag | output | 1 | Capture data available / request |
| buf_valid | output | 1 | Hidden buffer occupied |
| err_flag | output | 1 | Capture overflow occurred |

## Verification
A stuck or lost visible-valid bit shows up at the ports in one of two ways. Either a buffered stamp never reaches `cap_value` and `buf_valid` stays high, or a read at the next edge returns a stale value. Either symptom appears within one read.

A wrong overflow test shows up as an `err_flag` that is missing or spurious one edge after the second event. It also shows up as a corrupted value on the following reads, because the scoreboard queue then disagrees with `cap_value`. A wrong refill priority is visible as `chan_flag` dropping at a read that should have refilled the register.

// File: rtl/evt_capture_chan.sv
module evt_capture_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_in_en,
  input  logic             cap_en,
  input  logic             dual_slope,
  input  logic             top_below_half,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             evt_strobe,
  input  logic             rd_strobe,
  input  logic             clr_chan_flag,
  input  logic             clr_err_flag,
  output logic [CNT_W-1:0] cap_value,
  output logic             chan_flag,
  output logic             buf_valid,
  output logic             err_flag
);

  logic             vis_valid;
  logic [CNT_W-1:0] buf_data;
  logic [CNT_W-1:0] stamp;
  logic             fire, drain, overflow, ramp_tag;

  assign fire     = evt_strobe & evt_in_en & cap_en;
  assign overflow = fire & buf_valid;
  assign drain    = buf_valid & (~vis_valid | rd_strobe);
  assign ramp_tag = dual_slope & top_below_half;
  assign stamp    = ramp_tag ? {cnt_down, cnt_value[CNT_W-2:0]} : cnt_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
    end else if (fire && !buf_valid) begin
      buf_valid <= 1'b1;
      buf_data  <= stamp;
    end else if (drain) begin
      buf_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_valid <= 1'b0;
      cap_value <= '0;
    end else if (drain) begin
      vis_valid <= 1'b1;
      cap_value <= buf_data;
    end else if (rd_strobe) begin
      vis_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (drain)                                   chan_flag <= 1'b1;
      else if (clr_chan_flag || (rd_strobe && vis_valid)) chan_flag <= 1'b0;
      if (overflow)          err_flag <= 1'b1;
      else if (clr_err_flag) err_flag <= 1'b0;
    end
  end

  a_r1_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(evt_strobe && evt_in_en && cap_en) && !buf_valid) |=> !buf_valid);

  a_r3_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && (!vis_valid || rd_strobe)) |=> (vis_valid && chan_flag && cap_value == $past(buf_data)));

  a_r4_flag_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    chan_flag |-> vis_valid);

  a_r6_overflow_err: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_strobe && evt_in_en && cap_en && buf_valid) |=> err_flag);

  a_r6_overflow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && vis_valid && !rd_strobe) |=> (buf_valid && buf_data == $past(buf_data)));

  a_r8_ramp_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !buf_valid && dual_slope && top_below_half) |=> (buf_data[CNT_W-1] == $past(cnt_down)));

endmodule

// File: tb/evt_capture_chan_test.sv
module evt_capture_chan_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_in_en = 1'b0, cap_en = 1'b0, dual_slope = 1'b0, top_below_half = 1'b0;
  logic cnt_down = 1'b0, evt_strobe = 1'b0, rd_strobe = 1'b0;
  logic clr_chan_flag = 1'b0, clr_err_flag = 1'b0;
  logic [W-1:0] cnt_value = '0;
  logic [W-1:0] cap_value;
  logic chan_flag, buf_valid, err_flag;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expq[$];

  always #2 clk = ~clk;

  evt_capture_chan #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .evt_in_en(evt_in_en), .cap_en(cap_en),
    .dual_slope(dual_slope), .top_below_half(top_below_half), .cnt_down(cnt_down),
    .cnt_value(cnt_value), .evt_strobe(evt_strobe), .rd_strobe(rd_strobe),
    .clr_chan_flag(clr_chan_flag), .clr_err_flag(clr_err_flag),
    .cap_value(cap_value), .chan_flag(chan_flag), .buf_valid(buf_valid), .err_flag(err_flag));

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] model_stamp(logic [W-1:0] v, logic dn);
    return (dual_slope && top_below_half) ? {dn, v[W-2:0]} : v;
  endfunction

  task automatic capture(input logic [W-1:0] v, input logic dn, input bit stored);
    step();
    cnt_value = v; cnt_down = dn; evt_strobe = 1'b1;
    if (stored) expq.push_back(model_stamp(v, dn));
    step();
    evt_strobe = 1'b0;
  endtask

  task automatic rd();
    step(); rd_strobe = 1'b1;
    step(); rd_strobe = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_strobe) begin
      if (expq.size() == 0) chk(1'b0, "R5 unexpected read data", cap_value, '0);
      else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        chk(cap_value == e, "R5 fifo readout", cap_value, e);
      end
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1'b1;
    look();
    chk(!buf_valid && !chan_flag && !err_flag && cap_value == '0, "R9 reset state",
        {buf_valid, chan_flag, err_flag}, '0);

    cap_en = 1'b1;
    capture(16'h1111, 1'b0, 1'b0);
    look(); look();
    chk(!buf_valid && !chan_flag, "R1 event gated by evt_in_en", {buf_valid, chan_flag}, '0);
    evt_in_en = 1'b1; cap_en = 1'b0;
    capture(16'h2222, 1'b0, 1'b0);
    look(); look();
    chk(!buf_valid && !chan_flag && cap_value == '0, "R1 event gated by cap_en", cap_value, '0);
    cap_en = 1'b1;

    capture(16'h1234, 1'b0, 1'b1);
    look();
    chk(buf_valid && !chan_flag, "R10 buffer holds fresh stamp", {buf_valid, chan_flag}, 2'b10);
    step(); look();
    chk(!buf_valid && chan_flag && cap_value == 16'h1234, "R2 stamp visible", cap_value, 16'h1234);
    rd(); look();
    chk(!chan_flag, "R4 read clears flag", chan_flag, 1'b0);

    capture(16'h00A1, 1'b0, 1'b1);
    step();
    capture(16'h00B2, 1'b0, 1'b1);
    look();
    chk(buf_valid && chan_flag && cap_value == 16'h00A1, "R10 both stages full", cap_value, 16'h00A1);
    capture(16'h00C3, 1'b0, 1'b0);
    look();
    chk(err_flag, "R6 overflow sets error", err_flag, 1'b1);
    chk(buf_valid && cap_value == 16'h00A1, "R6 held data kept", cap_value, 16'h00A1);
    step(); rd_strobe = 1'b1;
    step(); rd_strobe = 1'b0;
    look();
    chk(chan_flag && cap_value == 16'h00B2 && !buf_valid, "R3 same-edge refill on read", cap_value, 16'h00B2);
    chk(chan_flag, "R4 flag stays with refill", chan_flag, 1'b1);
    step(); clr_chan_flag = 1'b1;
    step(); clr_chan_flag = 1'b0;
    look();
    chk(!chan_flag, "R4 clear input drops flag", chan_flag, 1'b0);
    rd();
    step(); clr_err_flag = 1'b1;
    step(); clr_err_flag = 1'b0;
    look();
    chk(!err_flag, "R7 error cleared", err_flag, 1'b0);

    step(); cnt_value = 16'h0D01; evt_strobe = 1'b1; expq.push_back(16'h0D01);
    step(); cnt_value = 16'h0D02;
    step(); evt_strobe = 1'b0;
    look();
    chk(err_flag, "R6 back-to-back overflow", err_flag, 1'b1);
    rd(); look();
    chk(!buf_valid && !chan_flag, "R6 second stamp dropped", {buf_valid, chan_flag}, '0);
    step(); clr_err_flag = 1'b1; step(); clr_err_flag = 1'b0;

    dual_slope = 1'b1; top_below_half = 1'b1;
    capture(16'h0005, 1'b1, 1'b1);
    step(); look();
    chk(cap_value == 16'h8005, "R8 falling ramp tag", cap_value, 16'h8005);
    rd();
    capture(16'h8005, 1'b0, 1'b1);
    step(); look();
    chk(cap_value == 16'h0005, "R8 rising ramp tag", cap_value, 16'h0005);
    rd();
    top_below_half = 1'b0;
    capture(16'h8005, 1'b1, 1'b1);
    step(); look();
    chk(cap_value == 16'h8005, "R8 no tag when top is large", cap_value, 16'h8005);
    rd();
    look();
    chk(expq.size() == 0, "R5 all stamps read", W'(expq.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule